// File: doc/BRIEF.md
# Consecutive-Sample Change Rule Monitor

This block is a synthesizable run-time monitor that sits beside a datapath. On every rising clock edge it takes one sample of a W-bit observed bus, `obs`, and compares it with the sample it took on the edge before. It also watches a pair of single-bit strobes, `cause` and `effect`.

Five rules can be checked. Four look at how the bus moves between two neighbouring samples:

- exactly one bit changes;
- exactly a fixed number of bits change;
- the value steps up, or down, by a fixed amount;
- the value moves by no more than a bounded distance.

The fifth rule is a latency rule. A `cause` pulse must be followed, a fixed number of cycles later, by `effect`. Each rule has its own enable input and its own sticky error flag. The step size, bit distance, range bound and latency are parameters.

A two-state controller decides when the neighbour rules may run:

- **ST_WARM** is entered on reset. No previous sample exists yet, so no neighbour rule is evaluated.
- **Transition ST_WARM → ST_RUN** is taken unconditionally on the first clock edge after reset. That edge also captures the first sample.
- **ST_RUN** holds until the next reset. In this state the neighbour rules are evaluated on every edge.

The latency rule does not use the controller. It is gated by its own delay line, which starts out empty after reset.

Top module: `chg_pattern_mon`

## Requirements
- R1: While reset is held and directly after it is released, all five error flags and `any_error` read 0.
- R2: The sample taken on the first clock edge after reset is never checked by any neighbour rule, whatever its value.
- R3: One-bit rule. When enabled, the flag `err_onebit` is set on an edge where the XOR of the new and previous samples does not have exactly one bit set. This includes an unchanged value.
- R4: Distance rule. When enabled, the flag `err_dist` is set on an edge where the XOR of the new and previous samples does not have exactly HDIST bits set.
- R5: Step rule, count-up mode (`dec_mode`=0). When enabled, the flag `err_step` is set unless (new − previous) mod 2^W equals STEP. A step from all-ones to zero is therefore legal.
- R6: Step rule, count-down mode (`dec_mode`=1). When enabled, the flag `err_step` is set unless (previous − new) mod 2^W equals STEP. A step from zero to all-ones is therefore legal.
- R7: Bound rule. When enabled, the flag `err_bound` is set when the smaller of the two modular differences between the samples exceeds RANGE.
- R8: Latency rule. When enabled, if `cause` is 1 on edge T and `effect` is 0 on edge T+LAT, the flag `err_lat` is set on edge T+LAT. `cause` pulses on consecutive edges each start their own check.
- R9: A rule whose enable input is 0 on an edge does not set its flag on that edge.
- R10: Flags are sticky and stay at 1 until an edge with `clr`=1 clears them. On an edge with `clr`=1, every flag becomes 0 even if a violation occurs on that same edge.
- R11: `any_error` is 1 exactly when at least one of the five flags is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Synchronous clear of all flags |
| obs | input | W | Observed bus |
| cause | input | 1 | Strobe that starts a latency check |
| effect | input | 1 | Strobe expected LAT cycles after `cause` |
| en_onebit | input | 1 | Enable of the one-bit rule |
| en_dist | input | 1 | Enable of the distance rule |
| en_step | input | 1 | Enable of the step rule |
| dec_mode | input | 1 | 0 = step counts up, 1 = step counts down |
| en_bound | input | 1 | Enable of the bound rule |
| en_lat | input | 1 | Enable of the latency rule |
| err_onebit | output | 1 | Sticky flag of the one-bit rule |
| err_dist | output | 1 | Sticky flag of the distance rule |
| err_step | output | 1 | Sticky flag of the step rule |
| err_bound | output | 1 | Sticky flag of the bound rule |
| err_lat | output | 1 | Sticky flag of the latency rule |
| any_error | output | 1 | OR of all five flags |

## Verification
The bench builds the block with W=8, STEP=1, HDIST=2, RANGE=3 and LAT=2. With an 8-bit bus, the wrap from 0xFF to 0x00 is cheap to reach, and a jump of 0xFE to 0x01 tests whether the bound rule measures distance modulo the bus width. HDIST=2 makes the one-bit rule and the distance rule conflict on every step, so one vector can trip one rule while the other passes. A latency of two lets back-to-back `cause` pulses overlap in the delay line within a few cycles, and shows that a satisfied check does not hide the one pending behind it.

// File: rtl/chg_mon_pkg.sv
package chg_mon_pkg;

    typedef enum logic {
        ST_WARM = 1'b0,
        ST_RUN  = 1'b1
    } mon_state_e;

    localparam int RULE_NUM   = 5;
    localparam int RI_ONEBIT  = 0;
    localparam int RI_DIST    = 1;
    localparam int RI_STEP    = 2;
    localparam int RI_BOUND   = 3;
    localparam int RI_LAT     = 4;

endpackage

// File: rtl/chg_pair_rules.sv
module chg_pair_rules #(
    parameter int W     = 8,
    parameter int STEP  = 1,
    parameter int HDIST = 2,
    parameter int RANGE = 3
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] prev,
    input  logic         dec_mode,
    output logic         onebit_bad,
    output logic         dist_bad,
    output logic         step_bad,
    output logic         bound_bad
);
    localparam logic [W-1:0] STEP_V  = W'(STEP);
    localparam logic [W-1:0] RANGE_V = W'(RANGE);
    localparam int           CW      = $clog2(W + 1);

    logic [W-1:0]  flip;
    logic [CW-1:0] nflip;
    logic [W-1:0]  d_up;
    logic [W-1:0]  d_dn;
    logic [W-1:0]  mag;

    always_comb begin
        flip  = cur ^ prev;
        nflip = '0;
        for (int i = 0; i < W; i++) begin
            nflip = nflip + CW'(flip[i]);
        end
        d_up = cur - prev;
        d_dn = prev - cur;
        mag  = (d_up < d_dn) ? d_up : d_dn;

        onebit_bad = (nflip != CW'(1));
        dist_bad   = (nflip != CW'(HDIST));
        step_bad   = dec_mode ? (d_dn != STEP_V) : (d_up != STEP_V);
        bound_bad  = (mag > RANGE_V);
    end

endmodule

// File: rtl/chg_lat_pipe.sv
module chg_lat_pipe #(
    parameter int LAT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cause,
    output logic due
);
    generate
        if (LAT == 1) begin : g_single
            logic stage_q;
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q <= 1'b0;
                else        stage_q <= cause;
            end
            assign due = stage_q;
        end else begin : g_chain
            logic [LAT-1:0] stage_q;
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q <= '0;
                else        stage_q <= {stage_q[LAT-2:0], cause};
            end
            assign due = stage_q[LAT-1];

            // R8: a pulse entering the chain reaches the next stage one edge later
            p_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
                cause |=> stage_q[0]);
        end
    endgenerate

endmodule

// File: rtl/chg_pattern_mon.sv
module chg_pattern_mon
    import chg_mon_pkg::*;
#(
    parameter int W     = 8,
    parameter int STEP  = 1,
    parameter int HDIST = 2,
    parameter int RANGE = 3,
    parameter int LAT   = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] obs,
    input  logic         cause,
    input  logic         effect,
    input  logic         en_onebit,
    input  logic         en_dist,
    input  logic         en_step,
    input  logic         dec_mode,
    input  logic         en_bound,
    input  logic         en_lat,
    output logic         err_onebit,
    output logic         err_dist,
    output logic         err_step,
    output logic         err_bound,
    output logic         err_lat,
    output logic         any_error
);
    mon_state_e          st_q, st_d;
    logic                pair_live;
    logic [W-1:0]        prev_q;
    logic                onebit_bad, dist_bad, step_bad, bound_bad;
    logic                lat_due;
    logic [RULE_NUM-1:0] rule_en;
    logic [RULE_NUM-1:0] rule_hit;
    logic [RULE_NUM-1:0] flag_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_WARM;
        else        st_q <= st_d;
    end

    // next state and outputs
    always_comb begin
        st_d      = st_q;
        pair_live = 1'b0;
        unique case (st_q)
            ST_WARM: begin
                st_d = ST_RUN;
            end
            ST_RUN: begin
                pair_live = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= obs;
    end

    chg_pair_rules #(.W(W), .STEP(STEP), .HDIST(HDIST), .RANGE(RANGE)) u_rules (
        .cur        (obs),
        .prev       (prev_q),
        .dec_mode   (dec_mode),
        .onebit_bad (onebit_bad),
        .dist_bad   (dist_bad),
        .step_bad   (step_bad),
        .bound_bad  (bound_bad)
    );

    chg_lat_pipe #(.LAT(LAT)) u_lat (
        .clk   (clk),
        .rst_n (rst_n),
        .cause (cause),
        .due   (lat_due)
    );

    always_comb begin
        rule_en              = '0;
        rule_hit             = '0;
        rule_en[RI_ONEBIT]   = en_onebit;
        rule_en[RI_DIST]     = en_dist;
        rule_en[RI_STEP]     = en_step;
        rule_en[RI_BOUND]    = en_bound;
        rule_en[RI_LAT]      = en_lat;
        rule_hit[RI_ONEBIT]  = pair_live & onebit_bad;
        rule_hit[RI_DIST]    = pair_live & dist_bad;
        rule_hit[RI_STEP]    = pair_live & step_bad;
        rule_hit[RI_BOUND]   = pair_live & bound_bad;
        rule_hit[RI_LAT]     = lat_due & ~effect;
    end

    generate
        for (genvar r = 0; r < RULE_NUM; r++) begin : g_flag
            always_ff @(posedge clk) begin
                if (!rst_n || clr) flag_q[r] <= 1'b0;
                else               flag_q[r] <= flag_q[r] | (rule_en[r] & rule_hit[r]);
            end
        end
    endgenerate

    assign err_onebit = flag_q[RI_ONEBIT];
    assign err_dist   = flag_q[RI_DIST];
    assign err_step   = flag_q[RI_STEP];
    assign err_bound  = flag_q[RI_BOUND];
    assign err_lat    = flag_q[RI_LAT];
    assign any_error  = |flag_q;

    // R2: the first sample after reset leaves every neighbour-rule flag at 0
    p_first_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WARM) |=> !(err_onebit | err_dist | err_step | err_bound));

    // R3: a live edge whose samples differ in other than one bit sets the flag
    p_onebit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && en_onebit && !clr && $countones(obs ^ prev_q) != 1)
        |=> err_onebit);

    // R8: a due latency check with no effect sets the flag
    p_lat_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_due && !effect && en_lat && !clr) |=> err_lat);

    // R9: a disabled rule keeps a clear flag clear
    p_off_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_step && !err_step && !clr) |=> !err_step);

    // R10: a set flag persists without a clear
    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_bound && !clr) |=> err_bound);

    // R10: a clear empties every flag
    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !any_error);

endmodule

// File: tb/chg_pattern_mon_tb.sv
module chg_pattern_mon_tb_top;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n, clr, cause, effect;
    logic [W-1:0] obs;
    logic         en_onebit, en_dist, en_step, dec_mode, en_bound, en_lat;
    logic         err_onebit, err_dist, err_step, err_bound, err_lat, any_error;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    chg_pattern_mon #(.W(W), .STEP(1), .HDIST(2), .RANGE(3), .LAT(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .obs(obs),
        .cause(cause), .effect(effect),
        .en_onebit(en_onebit), .en_dist(en_dist), .en_step(en_step),
        .dec_mode(dec_mode), .en_bound(en_bound), .en_lat(en_lat),
        .err_onebit(err_onebit), .err_dist(err_dist), .err_step(err_step),
        .err_bound(err_bound), .err_lat(err_lat), .any_error(any_error)
    );

    // vector fields: [13] clr, [12:5] obs, [4:0] expected {lat,bound,step,dist,onebit}
    localparam int NV = 14;
    localparam logic [13:0] VEC [0:NV-1] = '{
        {1'b0, 8'h55, 5'b00000},  // R2: first sample, never checked
        {1'b0, 8'h56, 5'b00001},  // R3: two bits flip
        {1'b1, 8'h57, 5'b00000},  // R10: clear
        {1'b0, 8'h58, 5'b00011},  // R3 R4: four bits flip
        {1'b1, 8'h58, 5'b00000},
        {1'b0, 8'h5B, 5'b00101},  // R5: step of 3
        {1'b1, 8'h5B, 5'b00000},
        {1'b0, 8'h5F, 5'b01110},  // R7: move of 4 > 3
        {1'b1, 8'hFF, 5'b00000},
        {1'b0, 8'h00, 5'b00011},  // R5: wrap FF->00 is a legal step
        {1'b1, 8'hFE, 5'b00000},
        {1'b0, 8'h01, 5'b00111},  // R7: FE->01 modular distance 3 is legal
        {1'b1, 8'h03, 5'b00000},
        {1'b0, 8'h03, 5'b00111}   // R3 R4 R5: unchanged value
    };

    function automatic string rule_tag(int b);
        case (b)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            3: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // drive at negedge, let one rising edge pass, return at the next negedge
    task automatic cyc(input logic c, input logic [W-1:0] o, input logic ca, input logic ef);
        clr = c; obs = o; cause = ca; effect = ef;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_en(input logic a, input logic b, input logic s, input logic d,
                          input logic bd, input logic l);
        en_onebit = a; en_dist = b; en_step = s; dec_mode = d; en_bound = bd; en_lat = l;
    endtask

    task automatic summary;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        rst_n = 1'b0; clr = 1'b0; obs = '0; cause = 1'b0; effect = 1'b0;
        set_en(1, 1, 1, 0, 1, 1);
        repeat (3) @(negedge clk);
        chk("R1 reset any_error", any_error, 1'b0);
        rst_n = 1'b1;
        chk("R1 after release", {err_lat, err_bound, err_step, err_dist, err_onebit} == 5'b0, 1'b1);

        for (int v = 0; v < NV; v++) begin
            cyc(VEC[v][13], VEC[v][12:5], 1'b0, 1'b0);
            for (int b = 0; b < 5; b++) begin
                logic [4:0] got;
                got = {err_lat, err_bound, err_step, err_dist, err_onebit};
                chk($sformatf("%s vec%0d", rule_tag(b), v), got[b], VEC[v][b]);
            end
            chk($sformatf("R11 vec%0d", v), any_error, |VEC[v][4:0]);
        end

        // R6: count-down mode, only the step rule on
        set_en(0, 0, 1, 1, 0, 0);
        cyc(1, 8'h10, 0, 0);
        cyc(0, 8'h0F, 0, 0);
        cyc(0, 8'h0E, 0, 0);
        chk("R6 down steps legal", err_step, 1'b0);
        cyc(0, 8'h00, 0, 0);
        chk("R6 step of 14 flagged", err_step, 1'b1);
        cyc(1, 8'h00, 0, 0);
        cyc(0, 8'hFF, 0, 0);
        chk("R6 wrap 00->FF legal", err_step, 1'b0);
        cyc(0, 8'h00, 0, 0);
        chk("R6 upward move flagged", err_step, 1'b1);

        // R9: everything disabled, wild moves and unanswered cause
        set_en(0, 0, 0, 0, 0, 0);
        cyc(1, 8'h00, 0, 0);
        cyc(0, 8'hA5, 1, 0);
        cyc(0, 8'hA5, 1, 0);
        cyc(0, 8'h3C, 0, 0);
        cyc(0, 8'h3C, 0, 0);
        chk("R9 disabled rules silent", any_error, 1'b0);

        // R8: latency of two, only latency rule on
        set_en(0, 0, 0, 0, 0, 1);
        cyc(1, 8'h00, 0, 0);
        cyc(1, 8'h00, 0, 0);
        cyc(0, 8'h00, 1, 0);
        cyc(0, 8'h00, 0, 0);
        cyc(0, 8'h00, 0, 1);
        chk("R8 answered cause", err_lat, 1'b0);
        cyc(0, 8'h00, 1, 0);
        cyc(0, 8'h00, 1, 0);
        cyc(0, 8'h00, 0, 1);
        chk("R8 first of pair answered", err_lat, 1'b0);
        cyc(0, 8'h00, 0, 0);
        chk("R8 second of pair missed", err_lat, 1'b1);
        chk("R11 any_error follows lat", any_error, 1'b1);

        // R10: sticky with the rule disabled, then cleared
        set_en(0, 0, 0, 0, 0, 0);
        cyc(0, 8'h00, 0, 1);
        cyc(0, 8'h00, 0, 1);
        chk("R10 flag held", err_lat, 1'b1);
        set_en(0, 0, 0, 0, 0, 1);
        cyc(0, 8'h00, 1, 0);
        cyc(0, 8'h00, 0, 0);
        cyc(1, 8'h00, 0, 0);
        chk("R10 clear wins over miss", err_lat, 1'b0);

        summary();
    end

endmodule